// File: doc/BRIEF.md
# Retention-Aware Row Refresh Scheduler

This block sits inside a DRAM memory controller and decides, row by row, whether a refresh is needed. Each pulse on the base-period tick starts one sweep. In a sweep, a row pointer visits every row address in ascending order. For each row, the block asks two retention bins whether they hold that row. Each bin is a Bloom filter. The block then either issues a refresh or skips the row. A refresh is a request to activate that one row address, and it is held until the command path grants it.

The interval rules are fixed. Rows in the short bin are refreshed on every base period. Rows in the middle bin are refreshed on every second period. All other rows are refreshed only once every four periods. A 2-bit period count, advanced at the end of each sweep, chooses which classes are due. Until the profiling-done input is raised, every row is refreshed in every sweep. Configuration software fills the bins through an insert port and can wipe both bins with a synchronous clear.

Top module: `retention_refresh_sched`

## Requirements
- R1: After reset, `refReq` is low, the row pointer is 0 and the period count is 0. No sweep starts until `baseTick` is pulsed.
- R2: A `baseTick` pulse starts one sweep that visits rows 0 up to 2^ROW_W-1 in ascending order. A pulse that arrives while a sweep is running queues exactly one further sweep, which follows it.
- R3: While `profDone` is low, every row is requested in every sweep.
- R4: With `profDone` high, a row found in bin 0 (the short bin) is requested in every sweep. Bin 0 is consulted first, so a row held in both bins follows the bin 0 rate.
- R5: The period count starts at 0 and increments by one at the end of each sweep, modulo 4. With `profDone` high, a row found only in bin 1 is requested when bit 0 of the period count is 0.
- R6: With `profDone` high, a row found in neither bin is requested only in sweeps whose period count is 0.
- R7: An insert (`insValid`, with `insBin` 0 or 1) sets two bits of the chosen bin. The bit positions are h0 and h1. h0 is the XOR of the row address, zero-extended and cut into log2(FILT_M)-bit chunks. h1 is h0 rotated left by 3, XORed with the pattern that has ones in the odd bit positions (0xAA for 8 bits). A row is a hit when both of its bits are set, so an inserted row is never missed.
- R8: `binClear` empties both bins on the next edge. It takes priority over an insert in the same cycle, which is dropped.
- R9: While `refReq` is high and `refGrant` is low, `refReq` stays high and `refRow` stays stable. The row pointer moves on only after a grant or a skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| binClear | input | 1 | Synchronous clear of both bins |
| insValid | input | 1 | Insert strobe |
| insBin | input | 1 | Target bin: 0 is the short interval, 1 the middle interval |
| insRow | input | ROW_W | Row address to insert |
| profDone | input | 1 | Profiling complete; enables per-row skipping |
| baseTick | input | 1 | One pulse per base period |
| refReq | output | 1 | Row activate request |
| refRow | output | ROW_W | Row address of the request |
| refGrant | input | 1 | Grant from the command path |

## Verification
The embedded assertions check properties that hold on every cycle:
- the request holds steady until it is granted;
- a due row raises a request on the cycle after it is examined, both in baseline mode and for bin 0 hits;
- a clear leaves both bit arrays empty;
- an insert makes the current row hit at once;
- the period count moves only at the end of a sweep.

Only the bench's scenarios can show the behaviour across whole sweeps:
- the full ascending row sequence;
- the queued second sweep;
- which rows each period value selects over four consecutive sweeps;
- that a clear issued together with an insert leaves nothing behind.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_REQ  = 2'd2
  } schedStateT;

  typedef struct packed {
    logic rowAdvance;
    logic periodInc;
  } ctrlStrobeT;

  localparam int NUM_BINS = 2;
  localparam int PERIOD_W = 2;

endpackage

// File: rtl/refresh_sched_datapath.sv
module refresh_sched_datapath
  import refresh_sched_pkg::*;
#(
  parameter int ROW_W  = 6,
  parameter int FILT_M = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                binClear,
  input  logic                insValid,
  input  logic                insBin,
  input  logic [ROW_W-1:0]    insRow,
  input  ctrlStrobeT          stb,
  output logic [ROW_W-1:0]    curRow,
  output logic                lastRow,
  output logic [PERIOD_W-1:0] period,
  output logic [NUM_BINS-1:0] binHit
);

  localparam int IDX_W  = $clog2(FILT_M);
  localparam int CHUNKS = (ROW_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = CHUNKS * IDX_W;
  localparam int ROT    = 3;

  function automatic logic [IDX_W-1:0] hashFold(input logic [ROW_W-1:0] r);
    logic [PAD_W-1:0] padded;
    logic [IDX_W-1:0] acc;
    padded = '0;
    padded[ROW_W-1:0] = r;
    acc = '0;
    for (int c = 0; c < CHUNKS; c++) begin
      acc = acc ^ padded[c*IDX_W +: IDX_W];
    end
    return acc;
  endfunction

  function automatic logic [IDX_W-1:0] hashRot(input logic [IDX_W-1:0] h0);
    logic [IDX_W-1:0] alt;
    for (int i = 0; i < IDX_W; i++) begin
      alt[i] = (i % 2) == 1;
    end
    return {h0[IDX_W-ROT-1:0], h0[IDX_W-1:IDX_W-ROT]} ^ alt;
  endfunction

  logic [ROW_W-1:0]    rowQ;
  logic [PERIOD_W-1:0] periodQ;
  logic [IDX_W-1:0]    insH0, insH1, curH0, curH1;

  assign insH0 = hashFold(insRow);
  assign insH1 = hashRot(insH0);
  assign curH0 = hashFold(rowQ);
  assign curH1 = hashRot(curH0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ    <= '0;
      periodQ <= '0;
    end else begin
      if (stb.rowAdvance) rowQ <= rowQ + 1'b1;
      if (stb.periodInc)  periodQ <= periodQ + 1'b1;
    end
  end

  assign curRow  = rowQ;
  assign lastRow = &rowQ;
  assign period  = periodQ;

  for (genvar b = 0; b < NUM_BINS; b++) begin : gBin
    logic [FILT_M-1:0] bits;
    logic              insHere;

    assign insHere = insValid && (insBin == b[0]);

    always_ff @(posedge clk) begin
      if (!rstN || binClear) begin
        bits <= '0;
      end else if (insHere) begin
        bits[insH0] <= 1'b1;
        bits[insH1] <= 1'b1;
      end
    end

    assign binHit[b] = bits[curH0] && bits[curH1];

    // R8: clear wins and leaves the array empty
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
      binClear |=> (bits == '0));

    // R7: no false negative for a row just inserted while the pointer rests on it
    assert_no_false_negative_R7: assert property (@(posedge clk) disable iff (!rstN)
      (insHere && !binClear && insRow == rowQ && !stb.rowAdvance) |=> binHit[b]);
  end

  // R5: the period count moves only on an end-of-sweep strobe
  assert_period_on_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(periodQ) |-> $past(stb.periodInc));

endmodule

// File: rtl/refresh_sched_ctrl.sv
module refresh_sched_ctrl
  import refresh_sched_pkg::*;
#(
  parameter int ROW_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                baseTick,
  input  logic                profDone,
  input  logic [NUM_BINS-1:0] binHit,
  input  logic [PERIOD_W-1:0] period,
  input  logic                lastRow,
  input  logic [ROW_W-1:0]    curRow,
  input  logic                refGrant,
  output logic                refReq,
  output ctrlStrobeT          stb
);

  schedStateT stateQ, stateD;
  logic       pendQ, pendD;
  logic       rowDue;
  logic       stepOn;

  always_comb begin
    rowDue = !profDone
          || binHit[0]
          || (binHit[1] && !period[0])
          || (period == '0);
  end

  always_comb begin
    stateD = stateQ;
    pendD  = pendQ || baseTick;
    stepOn = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (pendQ) begin
        stateD = ST_SCAN;
        pendD  = baseTick;
      end
      ST_SCAN: if (rowDue) stateD = ST_REQ;
               else stepOn = 1'b1;
      ST_REQ:  if (refGrant) stepOn = 1'b1;
      default: stateD = ST_IDLE;
    endcase
    if (stepOn) stateD = lastRow ? ST_IDLE : ST_SCAN;
    stb.rowAdvance = stepOn;
    stb.periodInc  = stepOn && lastRow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      pendQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      pendQ  <= pendD;
    end
  end

  assign refReq = (stateQ == ST_REQ);

  // R9: request and its row held until granted
  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !refGrant) |=> (refReq && $stable(curRow)));

  // R3: in baseline mode every examined row leads to a request
  assert_baseline_all_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SCAN && !profDone) |=> refReq);

  // R4: a bin 0 hit is always refreshed
  assert_short_bin_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SCAN && profDone && binHit[0]) |=> refReq);

endmodule

// File: rtl/retention_refresh_sched.sv
module retention_refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int ROW_W  = 6,
  parameter int FILT_M = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             binClear,
  input  logic             insValid,
  input  logic             insBin,
  input  logic [ROW_W-1:0] insRow,
  input  logic             profDone,
  input  logic             baseTick,
  output logic             refReq,
  output logic [ROW_W-1:0] refRow,
  input  logic             refGrant
);

  ctrlStrobeT          stb;
  logic [ROW_W-1:0]    curRow;
  logic                lastRow;
  logic [PERIOD_W-1:0] period;
  logic [NUM_BINS-1:0] binHit;

  refresh_sched_datapath #(.ROW_W(ROW_W), .FILT_M(FILT_M)) uDp (
    .clk(clk), .rstN(rstN), .binClear(binClear), .insValid(insValid),
    .insBin(insBin), .insRow(insRow), .stb(stb), .curRow(curRow),
    .lastRow(lastRow), .period(period), .binHit(binHit)
  );

  refresh_sched_ctrl #(.ROW_W(ROW_W)) uCtrl (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .profDone(profDone),
    .binHit(binHit), .period(period), .lastRow(lastRow), .curRow(curRow),
    .refGrant(refGrant), .refReq(refReq), .stb(stb)
  );

  assign refRow = curRow;

  // R1: no request in the cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    !rstN |=> !refReq);

endmodule

// File: tb/sim_retention_refresh_sched.sv
module sim_retention_refresh_sched;
  localparam int ROW_W = 6;
  localparam int NROWS = 1 << ROW_W;

  logic clk = 1'b0;
  logic rstN, binClear, insValid, insBin, profDone, baseTick, refReq, refGrant;
  logic [ROW_W-1:0] insRow, refRow;

  always #2 clk = ~clk;

  retention_refresh_sched #(.ROW_W(ROW_W), .FILT_M(256)) u0 (
    .clk(clk), .rstN(rstN), .binClear(binClear), .insValid(insValid),
    .insBin(insBin), .insRow(insRow), .profDone(profDone), .baseTick(baseTick),
    .refReq(refReq), .refRow(refRow), .refGrant(refGrant)
  );

  int errors = 0;
  int checks = 0;
  int sweeps = 0;
  bit finished = 0;
  bit modelBits [2][256];
  logic [ROW_W-1:0] got [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int h0(input int r);
    return r & 8'hFF;
  endfunction
  function automatic int h1(input int r);
    int a = h0(r);
    return (((a << 3) | (a >> 5)) & 8'hFF) ^ 8'hAA;
  endfunction
  function automatic bit inBin(input int b, input int r);
    return modelBits[b][h0(r)] && modelBits[b][h1(r)];
  endfunction

  task automatic insertRow(input int b, input int r);
    @(negedge clk);
    insValid = 1; insBin = b[0]; insRow = r[ROW_W-1:0];
    @(negedge clk);
    insValid = 0;
    modelBits[b][h0(r)] = 1;
    modelBits[b][h1(r)] = 1;
  endtask

  task automatic clearBins(input bit withInsert);
    @(negedge clk);
    binClear = 1;
    insValid = withInsert; insBin = 1'b0; insRow = 6'd20;
    @(negedge clk);
    binClear = 0; insValid = 0;
    for (int b = 0; b < 2; b++) for (int i = 0; i < 256; i++) modelBits[b][i] = 0;
  endtask

  // grant responder with varying delay; checks the hold rule (R9)
  initial begin
    refGrant = 0;
    forever begin
      @(negedge clk);
      if (refReq && !refGrant) begin
        logic [ROW_W-1:0] row0;
        int dly;
        row0 = refRow;
        dly = int'(row0) % 3;
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          check(refReq === 1'b1 && refRow === row0, "R9 request held", int'(refRow), int'(row0));
        end
        got.push_back(row0);
        refGrant = 1;
        @(negedge clk);
        refGrant = 0;
      end
    end
  end

  task automatic runSweeps(input int n, input string tag);
    int exp [$];
    int quiet;
    got.delete();
    @(negedge clk); baseTick = 1;
    @(negedge clk); baseTick = 0;
    if (n == 2) begin
      repeat (10) @(negedge clk);
      baseTick = 1; @(negedge clk); baseTick = 0;
    end
    quiet = 0;
    while (quiet < 150) begin
      @(negedge clk);
      if (refReq) quiet = 0; else quiet++;
    end
    for (int s = 0; s < n; s++) begin
      int p = sweeps % 4;
      for (int r = 0; r < NROWS; r++) begin
        if (!profDone || inBin(0, r) || (inBin(1, r) && (p % 2 == 0)) || p == 0)
          exp.push_back(r);
      end
      sweeps++;
    end
    check(got.size() == exp.size(), {tag, " request count"}, got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      check(int'(got[i]) == exp[i], {tag, " row order"}, int'(got[i]), exp[i]);
  endtask

  initial begin
    rstN = 0; binClear = 0; insValid = 0; insBin = 0; insRow = '0;
    profDone = 0; baseTick = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (20) @(negedge clk);
    check(refReq === 1'b0, "R1 idle after reset, R2 no sweep without tick", int'(refReq), 0);

    runSweeps(1, "R3 R2 baseline sweep");
    runSweeps(2, "R2 queued tick R3");

    insertRow(1, 20);
    clearBins(1'b1);
    insertRow(0, 5);  insertRow(0, 17); insertRow(0, 40);
    insertRow(1, 5);  insertRow(1, 9);  insertRow(1, 33); insertRow(1, 62);
    check(inBin(0, 20) == 0 && inBin(1, 20) == 0, "R8 model sanity", 0, 0);
    profDone = 1;
    for (int s = 0; s < 4; s++) runSweeps(1, "R4 R5 R6 R7 R8 binned sweep");

    clearBins(1'b0);
    for (int s = 0; s < 4; s++) runSweeps(1, "R8 R6 after clear");

    insertRow(0, 63); insertRow(1, 0); insertRow(1, 63);
    runSweeps(2, "R4 R5 R7 overlap");
    runSweeps(2, "R4 R5 R6 overlap second pair");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule